// File: doc/BRIEF.md
# Delay-Threshold Statistical Calibration Loop

This block is the digital half of a background trim loop for the finest delay-based comparison threshold of a ternary successive-approximation converter. It watches the late-stage two-bit digit that each conversion produces. A modulo-N counter moves up by one on each "above threshold" digit and down by one on each other legal digit. When the counter wraps, the block sends a one-clock pulse to an external charge pump, which nudges the stored threshold voltage up or down.

No reference is measured. The loop relies only on code statistics. It is at rest when the "above threshold" digit makes up half of the observed digits, because then the counter wanders around its midpoint and never wraps. That point places the time threshold at a quarter of full scale. The two coarser thresholds are not handled here. An enable input stops the loop while calibration is off.

Top module: `tcal_loop`

## Requirements
- R1: When calEn and digValid are high and digit is 2'b01, the counter rises by one at the next clock edge.
- R2: When calEn and digValid are high and digit is 2'b00 or 2'b10, the counter falls by one at the next clock edge.
- R3: Digit 2'b11 leaves the counter unchanged and causes no pulse.
- R4: The counter spans 0 to ACC_N-1 (ACC_N a power of two, default 64). A rise from ACC_N-1 wraps to 0 and drives rollUp high. A fall from 0 wraps to ACC_N-1 and drives rollDown high. The pulse appears in the cycle after the clock edge that sampled the digit.
- R5: While rstN is low, the counter returns to ACC_N/2 and both pulse outputs are low. From reset, the ACC_N/2-th consecutive rise gives the first rollUp, and the (ACC_N/2+1)-th consecutive fall gives the first rollDown.
- R6: Each pulse lasts one clock per wrap, and rollUp and rollDown are never high together.
- R7: With digValid low, the counter holds and no pulse is produced.
- R8: With calEn low, the counter holds and no pulse is produced, whatever digValid and digit are.
- R9: A stream in which 01 digits alternate with falling digits, starting from the reset midpoint, never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calEn | input | 1 | Calibration enable; low freezes the loop |
| digValid | input | 1 | Digit strobe, one per conversion |
| digit | input | 2 | Late-stage ternary digit: 01 above, 00/10 below, 11 unused |
| rollUp | output | 1 | One-clock pulse to raise the stored threshold |
| rollDown | output | 1 | One-clock pulse to lower the stored threshold |

## Verification
The embedded properties check on every cycle that the two pulses never overlap and that each pulse comes from a true wrap of the counter. They also check that the counter holds when there is no strobe or calibration is disabled, and that a 01 digit advances it by exactly one. Only the bench scenarios can show the pulse timing that the ports expose: the exact digit count from midpoint to the first wrap in each direction, the silence of a balanced stream, the inertness of digit 11, and agreement with a reference model over long biased random streams.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
  // Step command from decode to the counter.
  typedef struct packed {
    logic inc;
    logic dec;
  } stepCmd_t;

  localparam logic [1:0] DIG_ABOVE = 2'b01;
  localparam logic [1:0] DIG_UNUSED = 2'b11;
endpackage

// File: rtl/tcal_ctrl.sv
module tcal_ctrl
  import tcal_pkg::*;
(
  input  logic       calEn,
  input  logic       digValid,
  input  logic [1:0] digit,
  output stepCmd_t   cmd
);
  logic live;

  always_comb begin
    live    = calEn && digValid;
    cmd.inc = live && (digit == DIG_ABOVE);
    cmd.dec = live && (digit != DIG_ABOVE) && (digit != DIG_UNUSED);
  end
endmodule

// File: rtl/tcal_acc.sv
module tcal_acc
  import tcal_pkg::*;
#(
  parameter int ACC_N = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  stepCmd_t cmd,
  input  logic     calEn,
  input  logic     digValid,
  input  logic [1:0] digit,
  output logic     rollUp,
  output logic     rollDown
);
  localparam int ACC_W = $clog2(ACC_N);
  localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(ACC_N - 1);
  localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(ACC_N / 2);

  logic [ACC_W-1:0] accQ;
  logic             wrapHi;
  logic             wrapLo;

  always_comb begin
    wrapHi = cmd.inc && (accQ == ACC_TOP);
    wrapLo = cmd.dec && (accQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= ACC_MID;
      rollUp   <= 1'b0;
      rollDown <= 1'b0;
    end else begin
      rollUp   <= wrapHi;
      rollDown <= wrapLo;
      if (cmd.inc)      accQ <= accQ + 1'b1;
      else if (cmd.dec) accQ <= accQ - 1'b1;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rollUp && rollDown));  // R6
  AST_UP_FROM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    rollUp |-> (accQ == '0) && ($past(accQ) == ACC_TOP));  // R4
  AST_DN_FROM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    rollDown |-> (accQ == ACC_TOP) && ($past(accQ) == '0));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !digValid |=> $stable(accQ) && !rollUp && !rollDown);  // R7
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !calEn |=> $stable(accQ) && !rollUp && !rollDown);  // R8
  AST_ABOVE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (calEn && digValid && digit == 2'b01) |=> accQ == ACC_W'($past(accQ) + 1'b1));  // R1
  AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (digit == 2'b11) |=> $stable(accQ));  // R3
endmodule

// File: rtl/tcal_loop.sv
module tcal_loop
  import tcal_pkg::*;
#(
  parameter int ACC_N = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calEn,
  input  logic       digValid,
  input  logic [1:0] digit,
  output logic       rollUp,
  output logic       rollDown
);
  stepCmd_t cmd;

  tcal_ctrl i_ctrl (
    .calEn    (calEn),
    .digValid (digValid),
    .digit    (digit),
    .cmd      (cmd)
  );

  tcal_acc #(.ACC_N(ACC_N)) i_acc (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .calEn    (calEn),
    .digValid (digValid),
    .digit    (digit),
    .rollUp   (rollUp),
    .rollDown (rollDown)
  );
endmodule

// File: tb/test_tcal_loop.sv
module test_tcal_loop;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calEn = 1'b0;
  logic digValid = 1'b0;
  logic [1:0] digit = 2'b00;
  logic rollUp, rollDown;

  int checks = 0;
  int errors = 0;
  int mAcc = N / 2;
  int upSeen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tcal_loop #(.ACC_N(N)) i_tcal_loop (
    .clk(clk), .rstN(rstN), .calEn(calEn), .digValid(digValid),
    .digit(digit), .rollUp(rollUp), .rollDown(rollDown)
  );

  function automatic int stepOf(logic en, logic v, logic [1:0] d);
    if (!(en && v)) return 0;
    if (d == 2'b01) return 1;
    if (d == 2'b11) return 0;
    return -1;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, let a rising edge sample, check on the next falling edge.
  task automatic step(string req, logic en, logic v, logic [1:0] d);
    int s;
    logic eUp, eDn;
    calEn = en; digValid = v; digit = d;
    s = stepOf(en, v, d);
    eUp = 1'b0; eDn = 1'b0;
    if (s == 1) begin
      if (mAcc == N - 1) begin mAcc = 0; eUp = 1'b1; end else mAcc++;
    end else if (s == -1) begin
      if (mAcc == 0) begin mAcc = N - 1; eDn = 1'b1; end else mAcc--;
    end
    @(negedge clk);
    check(req, rollUp, eUp, "rollUp");
    check(req, rollDown, eDn, "rollDown");
    if (rollUp) upSeen++;
  endtask

  task automatic doReset();
    rstN = 1'b0; calEn = 1'b0; digValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R5", rollUp, 1'b0, "rollUp in reset");
    check("R5", rollDown, 1'b0, "rollDown in reset");
    rstN = 1'b1;
    mAcc = N / 2;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R5/R1/R4: N/2 rises from midpoint, wrap on the last
    for (int i = 0; i < N / 2; i++) step("R5", 1'b1, 1'b1, 2'b01);
    check("R4", upSeen == 1, 1'b1, "one rollUp after N/2 rises");
    step("R6", 1'b1, 1'b0, 2'b01);
    doReset();
    // R2/R5: N/2+1 falls alternating 00 and 10
    for (int i = 0; i < N / 2 + 1; i++) step("R2", 1'b1, 1'b1, (i % 2) ? 2'b10 : 2'b00);
    // R3: unused digit is inert
    for (int i = 0; i < N; i++) step("R3", 1'b1, 1'b1, 2'b11);
    // R7: no strobe
    for (int i = 0; i < N; i++) step("R7", 1'b1, 1'b0, 2'b01);
    // R8: disabled
    for (int i = 0; i < N; i++) step("R8", 1'b0, 1'b1, 2'b01);
    // R3/R7/R8 observed at ports: counter still at N-1, so one rise wraps
    step("R8", 1'b1, 1'b1, 2'b01);
    doReset();
    // R9: balanced stream never wraps
    for (int i = 0; i < 400; i++) step("R9", 1'b1, 1'b1, (i % 2) ? 2'b00 : 2'b01);
    // Random biased streams against the model
    void'($urandom(32'd7321));
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 2000; i++) begin
        int r;
        logic [1:0] d;
        r = $urandom_range(0, 99);
        d = (r < 35 + b * 10) ? 2'b01 : 2'($urandom_range(0, 3));
        step("R4", ($urandom_range(0, 9) != 0), ($urandom_range(0, 4) != 0), d);
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule